// File: doc/BRIEF.md
# Serial PHY Management Master with Command Word

This block runs single read and write transactions on a two-wire serial PHY management bus (MDC clock, bidirectional MDIO data). It is controlled through one 32-bit command/status word. Software writes a word that holds the operation, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then produces the whole serial frame on its pins. The data pin is split into a driven value, an output enable and a sampled input, so that the pad can be built outside the block.

Reading the word back shows the accepted command and a completion flag. When a read finishes, the returned register contents replace the data field. MDC is derived from the system clock: each bit period is `MDC_HALF` cycles with MDC low followed by `MDC_HALF` cycles with MDC high.

Top module: `mdio_cmd_master`

## Requirements
- R1: The command word holds the data in bits 15:0, the register address in bits 20:16, the PHY address in bits 25:21, a write request in bit 26 and a read request in bit 27. Once a command is accepted, the status word returns bits 27:0 as written, with bit 28 at 0 and bits 31:29 at 0.
- R2: Every frame starts with 35 bits of value 1, followed by the start pattern 0 then 1.
- R3: After the start pattern comes the operation: 0,1 for a write and 1,0 for a read.
- R4: The operation is followed by the PHY address and then the register address, each 5 bits long and sent most significant bit first.
- R5: A write then sends 1,0 and the 16 data bits, most significant bit first. Output enable stays high for the whole write frame, which is 67 bit periods long.
- R6: After the register address, a read drops output enable for one turnaround bit and then for 16 data bits. Each data bit is sampled from mdio_i on the rising edge of MDC, most significant bit first. At completion the 16 bits appear in status bits 15:0. A read frame is 66 bit periods long.
- R7: Each bit period has MDC low for MDC_HALF clock cycles, then high for MDC_HALF cycles. The first low phase begins in the cycle after the command is accepted. mdio_o and mdio_oe change only at the start of a bit period, while MDC is low.
- R8: In the cycle after the last bit period, status bit 28 reads 1. Accepting a new command clears it.
- R9: The block ignores a command with both bits 26 and 27 set, a command with neither bit set, and any command written while a frame is running. In each case the status word and the pins are left unchanged.
- R10: After reset the status word is 0, and mdc, mdio_o and mdio_oe are 0.
- R11: While no frame is running, mdc, mdio_o and mdio_oe are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Status word: accepted command, completion flag, read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value to drive on the management data pin |
| mdio_oe | output | 1 | Drive enable for the management data pin |
| mdio_i | input | 1 | Value sampled from the management data pin |

## Verification
A behavioural model predicts mdc, mdio_o, mdio_oe and the status word for every cycle, and the bench compares the design against it on every clock. The frames used are:
- a write with mixed data and alternating address bits, which separates bit order and field placement;
- a read whose returned value has only the top and bottom bits set, which exposes sampling off by one bit;
- a read at all-ones addresses returning all ones, which catches truncated fields;
- a write of all zeros, which shows the header bits apart from the data.

During the read turnaround the bench drives 0 on mdio_i, so a design that samples one bit early produces a visible error. Commands with both or neither operation bit set, and a command written in the middle of a read, check that the status word and the pins stay untouched.

// File: rtl/mdio_cmd_pkg.sv
// Package: shared field positions and frame constants for the
// management master. Assumes a 32-bit command/status word.
package mdio_cmd_pkg;
    localparam int CMD_W      = 32;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int REG_LSB    = 16;
    localparam int PHY_LSB    = 21;
    localparam int WR_BIT     = 26;
    localparam int RD_BIT     = 27;
    localparam int DONE_BIT   = 28;
    localparam int PRE_LEN    = 35;
    // header after preamble: start(2) op(2) phy(5) reg(5) ta(2) data(16)
    localparam int HDR_LEN    = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TA_OFS     = 2 + 2 + 2 * ADDR_W;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } opcode_t;
endpackage

// File: rtl/mdio_clk_gen.sv
// Module: MDC generator. While run is high, produces MDC with
// MDC_HALF clock cycles low followed by MDC_HALF cycles high, starting
// low. Flags the cycle before MDC rises (sample point) and the cycle
// before MDC falls (end of a bit). Assumes MDC_HALF >= 1.
module mdio_clk_gen #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic bit_end
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;

    // Purpose: count half periods and toggle MDC while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc       = mdc_q;
    assign rise_tick = run && !mdc_q && (cnt_q == LAST);
    assign bit_end   = run &&  mdc_q && (cnt_q == LAST);
endmodule

// File: rtl/mdio_frame_seq.sv
// Module: frame sequencer. On start, latches the header and walks the
// bit index across preamble and header, one bit per bit_end. Drives
// the data pin, releases it for read turnaround and data, and shifts
// in read data at each rise_tick. Assumes start only arrives when idle.
module mdio_frame_seq
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              bit_end,
    input  logic              mdio_i,
    output logic              busy,
    output logic              finish,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata
);
    localparam int FLEN_WR = PRE_LEN + HDR_LEN;
    localparam int FLEN_RD = PRE_LEN + HDR_LEN - 1;
    localparam int IW      = $clog2(FLEN_WR + 1);
    localparam logic [IW-1:0] LAST_WR  = IW'(FLEN_WR - 1);
    localparam logic [IW-1:0] LAST_RD  = IW'(FLEN_RD - 1);
    localparam logic [IW-1:0] PRE_I    = IW'(PRE_LEN);
    localparam logic [IW-1:0] TA_I     = IW'(PRE_LEN + TA_OFS);
    localparam logic [IW-1:0] DSTART_I = IW'(PRE_LEN + TA_OFS + 1);
    localparam int HW = $clog2(HDR_LEN);

    logic [IW-1:0]      idx_q;
    logic [HDR_LEN-1:0] hdr_q;
    logic               rd_q;
    logic               busy_q;
    logic [DATA_W-1:0]  shift_q;
    logic [IW-1:0]      last_idx;
    logic [IW-1:0]      hdr_off;
    opcode_t            opc;

    assign opc      = is_read ? OPC_READ : OPC_WRITE;
    assign last_idx = rd_q ? LAST_RD : LAST_WR;
    assign hdr_off  = idx_q - PRE_I;

    // Purpose: load the frame on start and step through its bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            rd_q   <= 1'b0;
            hdr_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            rd_q   <= is_read;
            hdr_q  <= {2'b01, opc, phy_addr, reg_addr, 2'b10, wdata};
        end else if (busy_q && bit_end) begin
            if (idx_q == last_idx) busy_q <= 1'b0;
            else                   idx_q  <= idx_q + 1'b1;
        end
    end

    // Purpose: shift in read data on each rising MDC edge of a data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (busy_q && rd_q && rise_tick && (idx_q >= DSTART_I)) begin
            shift_q <= {shift_q[DATA_W-2:0], mdio_i};
        end
    end

    // Purpose: choose the value and drive enable of the current bit.
    always_comb begin
        if (!busy_q) begin
            mdio_o  = 1'b0;
            mdio_oe = 1'b0;
        end else if (idx_q < PRE_I) begin
            mdio_o  = 1'b1;
            mdio_oe = 1'b1;
        end else if (rd_q && (idx_q >= TA_I)) begin
            mdio_o  = 1'b0;
            mdio_oe = 1'b0;
        end else begin
            mdio_o  = hdr_q[HW'(HDR_LEN - 1) - hdr_off[HW-1:0]];
            mdio_oe = 1'b1;
        end
    end

    assign busy   = busy_q;
    assign finish = busy_q && bit_end && (idx_q == last_idx);
    assign rdata  = shift_q;

    // R6: the data pin is released for the whole read data phase
    a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && rd_q && rise_tick && (idx_q >= DSTART_I)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_cmd_master.sv
// Module: top of the management master. Holds the command/status
// word, accepts a command only when idle and exactly one of the
// operation bits is set, starts the sequencer, and records completion
// and read data. Assumes software polls the completion bit.
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int MDC_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [RD_BIT:0]   cmd_q;
    logic              done_q;
    logic              accept;
    logic              busy;
    logic              finish;
    logic              rise_tick;
    logic              bit_end;
    logic [DATA_W-1:0] rdata;

    assign accept = cmd_wr && !busy && (cmd_wdata[WR_BIT] ^ cmd_wdata[RD_BIT]);

    // Purpose: keep the accepted command, completion flag and read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            done_q <= 1'b0;
        end else if (accept) begin
            cmd_q  <= cmd_wdata[RD_BIT:0];
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
            if (cmd_q[RD_BIT]) cmd_q[DATA_W-1:0] <= rdata;
        end
    end

    assign cmd_rdata = {{(CMD_W - DONE_BIT - 1){1'b0}}, done_q, cmd_q};

    mdio_clk_gen #(.MDC_HALF(MDC_HALF)) clk_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .bit_end   (bit_end)
    );

    mdio_frame_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .is_read   (cmd_wdata[RD_BIT]),
        .phy_addr  (cmd_wdata[PHY_LSB +: ADDR_W]),
        .reg_addr  (cmd_wdata[REG_LSB +: ADDR_W]),
        .wdata     (cmd_wdata[DATA_W-1:0]),
        .rise_tick (rise_tick),
        .bit_end   (bit_end),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .finish    (finish),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rdata     (rdata)
    );

    // R9: a write during a frame leaves the command fields unchanged
    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(cmd_q[RD_BIT:REG_LSB]));
    // R8: completion and a running frame never coexist
    a_r8_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done_q));
    // R8: completion rises only at the end of a running frame
    a_r8_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(busy));
    // R11: pins quiet while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe && !mdio_o));
    // R7: data pin holds while MDC stays high
    a_r7_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/mdio_cmd_master_tb_top.sv
module mdio_cmd_master_tb_top;
    localparam int HALF = 3;
    localparam int PER  = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    // model state
    bit        m_active = 0;
    int        m_cyc = 0;
    int        m_len = 0;
    bit        m_isrd = 0;
    logic [31:0] m_reg = '0;
    logic [15:0] phy_val = '0;
    bit        fb[$];
    bit        fo[$];
    bit        pend = 0;
    logic [31:0] pend_data = '0;

    always #10 clk = ~clk;

    mdio_cmd_master #(.MDC_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input int b);
        if (b < 37) return "R2";
        if (b < 39) return "R3";
        if (b < 49) return "R4";
        return m_isrd ? "R6" : "R5";
    endfunction

    task automatic build_frame(input logic [31:0] c);
        fb.delete(); fo.delete();
        for (int i = 0; i < 35; i++) begin fb.push_back(1); fo.push_back(1); end
        fb.push_back(0); fo.push_back(1); fb.push_back(1); fo.push_back(1);
        fb.push_back(c[27]); fo.push_back(1); fb.push_back(c[26]); fo.push_back(1);
        for (int i = 25; i >= 16; i--) begin fb.push_back(c[i]); fo.push_back(1); end
        if (c[27]) begin
            for (int i = 0; i < 17; i++) begin fb.push_back(0); fo.push_back(0); end
        end else begin
            fb.push_back(1); fo.push_back(1); fb.push_back(0); fo.push_back(1);
            for (int i = 15; i >= 0; i--) begin fb.push_back(c[i]); fo.push_back(1); end
        end
        m_len = fb.size();
    endtask

    // cycle-by-cycle reference model, evaluated away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_reg = '0; m_cyc = 0;
        end else begin
            bit was_active;
            int b;
            bit e_mdc, e_oe, e_o;
            was_active = m_active;
            if (m_active) begin
                m_cyc++;
                if (m_cyc == m_len * PER) begin
                    m_active = 0;
                    m_reg[28] = 1'b1;
                    if (m_isrd) m_reg[15:0] = phy_val;
                end
            end
            if (pend && !was_active && (pend_data[26] ^ pend_data[27])) begin
                m_reg = {4'b0, pend_data[27:0]};
                m_isrd = pend_data[27];
                build_frame(pend_data);
                m_active = 1; m_cyc = 0;
            end
            if (m_active) begin
                b = m_cyc / PER;
                e_mdc = (m_cyc % PER) >= HALF;
                e_oe = fo[b];
                e_o = e_oe ? fb[b] : 1'b0;
                check(mdc == e_mdc, "R7 mdc", 32'(mdc), 32'(e_mdc));
                check(mdio_oe == e_oe, tag_of(b), 32'(mdio_oe), 32'(e_oe));
                check(mdio_o == e_o, tag_of(b), 32'(mdio_o), 32'(e_o));
                if (m_isrd && b >= 50 && b < 66) mdio_i = phy_val[15 - (b - 50)];
                else if (m_isrd && b == 49) mdio_i = 1'b0;
                else mdio_i = 1'b1;
            end else begin
                check(!mdc && !mdio_oe && !mdio_o, "R11 idle pins",
                      32'({mdc, mdio_oe, mdio_o}), 32'(0));
                mdio_i = 1'b1;
            end
            check(cmd_rdata == m_reg, "R1 R6 R8 status", cmd_rdata, m_reg);
        end
        pend = cmd_wr;
        pend_data = cmd_wdata;
    end

    task automatic issue(input logic [31:0] c);
        @(posedge clk); #2;
        cmd_wr = 1'b1; cmd_wdata = c;
        @(posedge clk); #2;
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(posedge clk);
        wait (!m_active);
        repeat (4) @(posedge clk);
    endtask

    function automatic logic [31:0] mk(input bit rd, input bit wr, input logic [4:0] pa,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {4'b0, rd, wr, pa, ra, d};
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] c;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        // R10: reset state
        check(cmd_rdata == 32'h0, "R10 status", cmd_rdata, 32'h0);
        check(!mdc && !mdio_o && !mdio_oe, "R10 pins", 32'({mdc, mdio_o, mdio_oe}), 32'h0);

        // R5: write frame, mixed pattern
        c = mk(0, 1, 5'h15, 5'h0A, 16'hA53C);
        issue(c);
        @(negedge clk); #1;
        check(cmd_rdata == c, "R1 accepted word, done clear", cmd_rdata, c);
        wait_idle();
        check(cmd_rdata == (c | 32'h1000_0000), "R8 write done", cmd_rdata, c | 32'h1000_0000);

        // R9: both operation bits set is ignored
        issue(mk(1, 1, 5'h03, 5'h04, 16'h1234));
        repeat (4) @(negedge clk); #1;
        check(cmd_rdata == (c | 32'h1000_0000), "R9 both bits ignored", cmd_rdata, c | 32'h1000_0000);
        check(!mdio_oe && !mdc, "R9 pins quiet", 32'({mdio_oe, mdc}), 32'h0);
        // R9: neither bit set is ignored
        issue(mk(0, 0, 5'h07, 5'h08, 16'h5678));
        repeat (4) @(negedge clk); #1;
        check(cmd_rdata == (c | 32'h1000_0000), "R9 no op ignored", cmd_rdata, c | 32'h1000_0000);

        // R6: read with edge bits set, plus a command written mid-frame (R9)
        phy_val = 16'h8001;
        c = mk(1, 0, 5'h01, 5'h02, 16'h0000);
        issue(c);
        repeat (40) @(posedge clk);
        issue(mk(0, 1, 5'h1F, 5'h1F, 16'hFFFF));
        wait_idle();
        check(cmd_rdata == {4'b0001, c[27:16], 16'h8001}, "R6 R9 read result",
              cmd_rdata, {4'b0001, c[27:16], 16'h8001});

        // R4 R6: all-ones addresses, all-ones data
        phy_val = 16'hFFFF;
        c = mk(1, 0, 5'h1F, 5'h1F, 16'h0000);
        issue(c);
        wait_idle();
        check(cmd_rdata == {4'b0001, c[27:16], 16'hFFFF}, "R6 read ones",
              cmd_rdata, {4'b0001, c[27:16], 16'hFFFF});

        // R3 R5: all-zero write
        c = mk(0, 1, 5'h00, 5'h00, 16'h0000);
        issue(c);
        wait_idle();
        check(cmd_rdata == (c | 32'h1000_0000), "R3 R5 zero write", cmd_rdata, c | 32'h1000_0000);

        finish_run();
    end

    initial begin
        #(20ns * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule